// File: doc/BRIEF.md
# Context-Flushed Translation Buffer with Access Checks

This block is a small fully associative translation buffer for a single access stream, either instruction fetches or data accesses. An external walker fills it one 32-bit page descriptor at a time. Each descriptor is tagged with the virtual page number (VPN) it maps. A lookup gives the physical address, a cacheability verdict and any access violation one clock after the request. Every lookup result is registered.

The descriptor layout is fixed. Bits 31:30 hold the entry kind. Then come one bit each for cacheable (29), writable (28), executable (27), user-allowed (26), global (25) and dirty (24). The physical page number (PPN) sits in bits 23:0.

Software controls the buffer through a single write port carrying an operation code and a VPN-wide data word. The operations are:
- a context switch, which clears every entry that is not global;
- a mode write, which turns translation on or off;
- a single-line invalidate by VPN.

On a violation, the faulting virtual address and a cause code are captured in two read-only registers exposed as outputs.

Top module: `ctx_tlb`

## Requirements
- R1: After reset:
  - no response is flagged;
  - `bad_vaddr` and `exc_code` are zero;
  - translation is disabled.
- R2: With translation on, a request whose VPN matches a live entry gives `rsp_valid` and `rsp_hit` on the next cycle. `rsp_paddr` is then {PPN, page offset} and `rsp_code` is 0.
- R3: A request whose VPN matches no live entry gives `rsp_miss` and `rsp_code` = 4 on the next cycle. `bad_vaddr` and `exc_code` keep their values.
- R4: A write to a hit page whose writable bit is 0 gives `rsp_fault` and code 1. The request address is latched into `bad_vaddr` and 1 into `exc_code`. This check has the highest priority.
- R5: A fetch (`req_exec`) to a hit page whose executable bit is 0 gives code 2. Code 2 is latched like R4 and ranks below the write check.
- R6: A user-mode access to a hit page whose user bit is 0 gives code 3. Code 3 is latched like R4 and ranks lowest.
- R7: `rsp_cacheable` depends on the case:
  - on a clean hit, it is the page cacheable bit AND `seg_cacheable` sampled with the request;
  - with translation off, it equals `seg_cacheable`;
  - on a miss or a fault, it is 0.
- R8: A write that hits a page it may write, whose dirty bit is 0, raises `rsp_dirty_req` with the response. The request is not raised otherwise.
- R9: Operation 0 (context switch) invalidates every entry whose global bit is 0. Global entries keep translating.
- R10: Operation 2 compares `cfg_wdata` with the stored VPNs and invalidates the matching entry, global or not. A value that matches nothing has no effect.
- R11: A fill goes into the lowest-numbered free entry. When all entries are live, a round-robin pointer picks the victim, starting at entry 0 and advancing by one per such eviction.
- R12: Operation 1 sets translation on when `cfg_wdata[0]` is 1 and off when it is 0. While off, `rsp_paddr` is the virtual address zero-extended and `rsp_hit` is set.
- R13: A fill whose descriptor kind (bits 31:30) is 0 installs nothing and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Software write strobe |
| cfg_op | input | 2 | Operation: 0 context switch, 1 mode, 2 line invalidate |
| cfg_wdata | input | VA_W-PAGE_W | Mode bit (bit 0) or VPN to invalidate |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-PAGE_W | VPN tag of the refill |
| fill_desc | input | 32 | Page descriptor of the refill |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a store |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| seg_cacheable | input | 1 | Cacheability of the physical segment |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No live entry matched |
| rsp_fault | output | 1 | Permission violation |
| rsp_code | output | 3 | Outcome code 0..4 |
| rsp_paddr | output | 24+PAGE_W | Physical address |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_dirty_req | output | 1 | Walker should set the dirty bit in memory |
| bad_vaddr | output | VA_W | Last faulting virtual address |
| exc_code | output | 3 | Last fault cause |

## Verification
The checks assume the following about the inputs:
- `req_valid` is low while reset is held;
- at most one of `req_write` and `req_exec` is set per request;
- the walker never fills a VPN that is already live, so at most one entry matches any key;
- software writes and fills are not issued in the same cycle.

The directed bench keeps within these limits. It drives one operation per falling edge and uses a distinct VPN for every fill. It deasserts every strobe one cycle after raising it.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
   localparam int DESC_W = 32;
   localparam int PPN_W  = 24;

   typedef struct packed {
      logic [1:0]       kind;
      logic             cach;
      logic             wr;
      logic             ex;
      logic             usr;
      logic             glob;
      logic             dirty;
      logic [PPN_W-1:0] ppn;
   } pte_t;

   typedef enum logic [2:0] {
      EXC_NONE  = 3'd0,
      EXC_WRITE = 3'd1,
      EXC_EXEC  = 3'd2,
      EXC_USER  = 3'd3,
      EXC_MISS  = 3'd4
   } exc_e;

   typedef enum logic [1:0] {
      OP_CTX   = 2'd0,
      OP_MODE  = 2'd1,
      OP_INVAL = 2'd2,
      OP_NONE  = 2'd3
   } cfg_op_e;
endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20
) (
   input  logic [ENTRIES-1:0]            live,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            hit_vec
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = live[g] && (tags[g] == key);
   end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
   parameter int ENTRIES    = 8,
   parameter bit FREE_FIRST = 1'b1,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] live,
   input  logic               advance,
   output logic [IDX_W-1:0]   victim
);
   logic [IDX_W-1:0] rr_q;
   logic             use_free;
   logic [IDX_W-1:0] free_idx;

   if (FREE_FIRST) begin : g_free_first
      always_comb begin
         use_free = 1'b0;
         free_idx = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
               use_free = 1'b1;
               free_idx = IDX_W'(i);
            end
         end
      end
   end else begin : g_pure_rr
      assign use_free = 1'b0;
      assign free_idx = '0;
   end

   assign victim = use_free ? free_idx : rr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (advance && !use_free) begin
         rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end
endmodule

// File: rtl/ctx_tlb_perm.sv
module ctx_tlb_perm
   import ctx_tlb_pkg::*;
(
   input  pte_t pte,
   input  logic write,
   input  logic exec,
   input  logic user,
   output exc_e code
);
   always_comb begin
      if (write && !pte.wr)      code = EXC_WRITE;
      else if (exec && !pte.ex)  code = EXC_EXEC;
      else if (user && !pte.usr) code = EXC_USER;
      else                       code = EXC_NONE;
   end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int ENTRIES    = 8,
   parameter int VA_W       = 32,
   parameter int PAGE_W     = 12,
   parameter bit FREE_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [1:0]               cfg_op,
   input  logic [VA_W-PAGE_W-1:0]   cfg_wdata,
   input  logic                     fill_valid,
   input  logic [VA_W-PAGE_W-1:0]   fill_vpn,
   input  logic [DESC_W-1:0]        fill_desc,
   input  logic                     req_valid,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic                     req_write,
   input  logic                     req_exec,
   input  logic                     req_user,
   input  logic                     seg_cacheable,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic                     rsp_miss,
   output logic                     rsp_fault,
   output logic [2:0]               rsp_code,
   output logic [PPN_W+PAGE_W-1:0]  rsp_paddr,
   output logic                     rsp_cacheable,
   output logic                     rsp_dirty_req,
   output logic [VA_W-1:0]          bad_vaddr,
   output logic [2:0]               exc_code
);
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PA_W  = PPN_W + PAGE_W;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2)                   $error("ctx_tlb: ENTRIES must be at least 2");
   if (PAGE_W < 1 || PAGE_W >= VA_W)  $error("ctx_tlb: PAGE_W out of range");
   if (PA_W < VA_W)                   $error("ctx_tlb: physical address narrower than virtual");

   // entry storage
   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0]            live;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   pte_t [ENTRIES-1:0]            pte_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_live
      assign live[g] = valid_q[g] && (pte_q[g].kind != 2'b00);
   end

   // lookup and invalidate matching
   logic [VPN_W-1:0]   req_vpn;
   logic [ENTRIES-1:0] look_hit_vec;
   logic [ENTRIES-1:0] inval_vec;
   pte_t               hit_pte;
   exc_e               perm_code;
   exc_e               nxt_code;

   assign req_vpn = req_vaddr[VA_W-1:PAGE_W];

   ctx_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_look (
      .live(live), .tags(tag_q), .key(req_vpn), .hit_vec(look_hit_vec));

   ctx_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_inval (
      .live(live), .tags(tag_q), .key(cfg_wdata), .hit_vec(inval_vec));

   always_comb begin
      hit_pte = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (look_hit_vec[i]) hit_pte = pte_t'(hit_pte | pte_q[i]);
      end
   end

   ctx_tlb_perm u_perm (
      .pte(hit_pte), .write(req_write), .exec(req_exec), .user(req_user), .code(perm_code));

   // refill placement
   logic             fill_ok;
   logic [IDX_W-1:0] victim;
   pte_t             fill_pte;

   assign fill_pte = pte_t'(fill_desc);
   assign fill_ok  = fill_valid && (fill_pte.kind != 2'b00);

   ctx_tlb_victim #(.ENTRIES(ENTRIES), .FREE_FIRST(FREE_FIRST)) u_victim (
      .clk(clk), .rst_n(rst_n), .live(live), .advance(fill_ok), .victim(victim));

   // control state
   logic            en_q;
   logic            rsp_valid_q;
   exc_e            code_q;
   logic [PA_W-1:0] paddr_q;
   logic            cache_q;
   logic            dirty_q;
   logic [PA_W-1:0] nxt_paddr;
   logic            nxt_cache;
   logic            nxt_dirty;
   logic            nxt_fault;

   always_comb begin
      if (!en_q)                   nxt_code = EXC_NONE;
      else if (look_hit_vec == '0) nxt_code = EXC_MISS;
      else                         nxt_code = perm_code;
      nxt_paddr = en_q ? {hit_pte.ppn, req_vaddr[PAGE_W-1:0]} : PA_W'(req_vaddr);
      nxt_cache = req_valid && (nxt_code == EXC_NONE) && seg_cacheable && (!en_q || hit_pte.cach);
      nxt_dirty = req_valid && en_q && (nxt_code == EXC_NONE) && req_write && !hit_pte.dirty;
      nxt_fault = req_valid && (nxt_code inside {EXC_WRITE, EXC_EXEC, EXC_USER});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         tag_q   <= '0;
         pte_q   <= '0;
      end else begin
         if (fill_ok) begin
            valid_q[victim] <= 1'b1;
            tag_q[victim]   <= fill_vpn;
            pte_q[victim]   <= fill_pte;
         end
         if (cfg_we && cfg_op == OP_CTX) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (!pte_q[i].glob) valid_q[i] <= 1'b0;
            end
         end
         if (cfg_we && cfg_op == OP_INVAL) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (inval_vec[i]) valid_q[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q        <= 1'b0;
         rsp_valid_q <= 1'b0;
         code_q      <= EXC_NONE;
         paddr_q     <= '0;
         cache_q     <= 1'b0;
         dirty_q     <= 1'b0;
         bad_vaddr   <= '0;
         exc_code    <= '0;
      end else begin
         if (cfg_we && cfg_op == OP_MODE) en_q <= cfg_wdata[0];
         rsp_valid_q <= req_valid;
         code_q      <= req_valid ? nxt_code : EXC_NONE;
         paddr_q     <= nxt_paddr;
         cache_q     <= nxt_cache;
         dirty_q     <= nxt_dirty;
         if (nxt_fault) begin
            bad_vaddr <= req_vaddr;
            exc_code  <= nxt_code;
         end
      end
   end

   assign rsp_valid     = rsp_valid_q;
   assign rsp_code      = code_q;
   assign rsp_hit       = rsp_valid_q && (code_q == EXC_NONE);
   assign rsp_miss      = rsp_valid_q && (code_q == EXC_MISS);
   assign rsp_fault     = rsp_valid_q && (code_q inside {EXC_WRITE, EXC_EXEC, EXC_USER});
   assign rsp_paddr     = paddr_q;
   assign rsp_cacheable = cache_q;
   assign rsp_dirty_req = dirty_q;
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               seg_cacheable,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_fault,
   input logic [2:0]         rsp_code,
   input logic               rsp_cacheable,
   input logic               rsp_dirty_req,
   input logic [VA_W-1:0]    bad_vaddr,
   input logic [2:0]         exc_code,
   input logic [ENTRIES-1:0] look_hit_vec
);
   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   p_miss_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> ($stable(bad_vaddr) && $stable(exc_code)));

   p_fault_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (exc_code == rsp_code && exc_code != 3'd0));

   p_cache_needs_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cacheable |-> (rsp_valid && !rsp_miss && !rsp_fault && $past(seg_cacheable)));

   p_dirty_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_dirty_req |-> rsp_hit);

   p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit_vec));
endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_ctx_tlb_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_cacheable(seg_cacheable),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
   .rsp_code(rsp_code), .rsp_cacheable(rsp_cacheable), .rsp_dirty_req(rsp_dirty_req),
   .bad_vaddr(bad_vaddr), .exc_code(exc_code), .look_hit_vec(look_hit_vec));

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_op = 2'd3;
   logic [19:0] cfg_wdata = '0;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_desc = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0, seg_cacheable = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_cacheable, rsp_dirty_req;
   logic [2:0]  rsp_code, exc_code;
   logic [35:0] rsp_paddr;
   logic [31:0] bad_vaddr;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   ctx_tlb i_ctx_tlb (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_wdata(cfg_wdata),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_desc(fill_desc),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
      .req_exec(req_exec), .req_user(req_user), .seg_cacheable(seg_cacheable),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
      .rsp_dirty_req(rsp_dirty_req), .bad_vaddr(bad_vaddr), .exc_code(exc_code));

   task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] desc(input logic [1:0] k, input logic c, input logic w,
                                        input logic x, input logic u, input logic g,
                                        input logic d, input logic [23:0] ppn);
      return {k, c, w, x, u, g, d, ppn};
   endfunction

   task automatic do_cfg(input logic [1:0] op, input logic [19:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_op = op; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0; cfg_op = 2'd3;
   endtask

   task automatic do_fill(input logic [19:0] vpn, input logic [31:0] d);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_desc = d;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_req(input logic [31:0] va, input logic w, input logic x,
                         input logic u, input logic seg);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = w; req_exec = x; req_user = u;
      seg_cacheable = seg;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0;
   endtask

   task automatic t_reset();
      check(!rsp_valid, "R1 rsp_valid", 64'(rsp_valid), 0);
      check(bad_vaddr == 0, "R1 bad_vaddr", 64'(bad_vaddr), 0);
      check(exc_code == 0, "R1 exc_code", 64'(exc_code), 0);
   endtask

   task automatic t_passthrough();
      do_req(32'h1234_5678, 0, 0, 0, 1);
      check(rsp_hit && !rsp_miss, "R1 disabled after reset", 64'(rsp_miss), 0);
      check(rsp_paddr == 36'h0_1234_5678, "R12 passthrough paddr", 64'(rsp_paddr), 64'h12345678);
      check(rsp_cacheable == 1'b1, "R7 seg only when off", 64'(rsp_cacheable), 1);
      do_req(32'h1234_5678, 0, 0, 0, 0);
      check(rsp_cacheable == 1'b0, "R7 seg low when off", 64'(rsp_cacheable), 0);
   endtask

   task automatic t_hit();
      do_cfg(2'd1, 20'h1);
      do_fill(20'h00010, desc(2'b01, 1, 1, 1, 1, 0, 1, 24'hABCDE1));
      do_req({20'h00010, 12'h345}, 0, 0, 1, 1);
      check(rsp_valid && rsp_hit && rsp_code == 0, "R2 hit", 64'(rsp_code), 0);
      check(rsp_paddr == {24'hABCDE1, 12'h345}, "R2 paddr", 64'(rsp_paddr), 64'hABCDE1345);
      check(rsp_cacheable, "R7 page and seg", 64'(rsp_cacheable), 1);
      do_req({20'h00010, 12'h345}, 0, 0, 0, 0);
      check(!rsp_cacheable, "R7 seg blocks", 64'(rsp_cacheable), 0);
   endtask

   task automatic t_miss();
      do_req({20'h00099, 12'h001}, 0, 0, 0, 1);
      check(rsp_miss && rsp_code == 3'd4, "R3 miss code", 64'(rsp_code), 4);
      check(bad_vaddr == 0 && exc_code == 0, "R3 regs unchanged", 64'(exc_code), 0);
      check(!rsp_cacheable, "R7 no cache on miss", 64'(rsp_cacheable), 0);
   endtask

   task automatic t_faults();
      do_fill(20'h00020, desc(2'b01, 0, 0, 0, 0, 0, 0, 24'h000222));
      do_req({20'h00020, 12'h010}, 1, 0, 1, 1);
      check(rsp_fault && rsp_code == 3'd1, "R4 write code wins", 64'(rsp_code), 1);
      check(bad_vaddr == 32'h0002_0010 && exc_code == 3'd1, "R4 latched", 64'(bad_vaddr), 64'h20010);
      do_req({20'h00020, 12'h020}, 0, 1, 1, 1);
      check(rsp_code == 3'd2 && exc_code == 3'd2, "R5 exec code", 64'(rsp_code), 2);
      check(bad_vaddr == 32'h0002_0020, "R5 latched", 64'(bad_vaddr), 64'h20020);
      do_req({20'h00020, 12'h030}, 0, 0, 1, 1);
      check(rsp_code == 3'd3 && exc_code == 3'd3, "R6 user code", 64'(rsp_code), 3);
      check(bad_vaddr == 32'h0002_0030, "R6 latched", 64'(bad_vaddr), 64'h20030);
      do_req({20'h00020, 12'h040}, 0, 0, 0, 1);
      check(rsp_hit && exc_code == 3'd3, "R6 supervisor read ok", 64'(rsp_code), 0);
      do_req({20'h000AA, 12'h000}, 0, 0, 0, 1);
      check(exc_code == 3'd3 && bad_vaddr == 32'h0002_0030, "R3 miss keeps regs", 64'(exc_code), 3);
   endtask

   task automatic t_dirty();
      do_fill(20'h00030, desc(2'b01, 1, 1, 1, 1, 0, 0, 24'h000333));
      do_req({20'h00030, 12'h0}, 1, 0, 0, 1);
      check(rsp_hit && rsp_dirty_req, "R8 clean write", 64'(rsp_dirty_req), 1);
      do_req({20'h00030, 12'h0}, 0, 0, 0, 1);
      check(!rsp_dirty_req, "R8 read no request", 64'(rsp_dirty_req), 0);
      do_req({20'h00010, 12'h0}, 1, 0, 0, 1);
      check(!rsp_dirty_req, "R8 dirty page", 64'(rsp_dirty_req), 0);
   endtask

   task automatic t_ctx();
      do_fill(20'h00040, desc(2'b01, 1, 1, 1, 1, 1, 1, 24'h000444));
      do_cfg(2'd0, 20'h0);
      do_req({20'h00040, 12'h0}, 0, 0, 0, 1);
      check(rsp_hit && rsp_paddr[35:12] == 24'h444, "R9 global kept", 64'(rsp_paddr), 64'h444000);
      do_req({20'h00010, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R9 local flushed", 64'(rsp_code), 4);
      do_req({20'h00030, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R9 local flushed 2", 64'(rsp_code), 4);
   endtask

   task automatic t_inval();
      do_cfg(2'd2, 20'h00077);
      do_req({20'h00040, 12'h0}, 0, 0, 0, 1);
      check(rsp_hit, "R10 no match no effect", 64'(rsp_code), 0);
      do_cfg(2'd2, 20'h00040);
      do_req({20'h00040, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R10 global line invalidated", 64'(rsp_code), 4);
   endtask

   task automatic t_kind0();
      do_fill(20'h00060, desc(2'b00, 1, 1, 1, 1, 0, 1, 24'h000666));
      do_req({20'h00060, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R13 kind 0 ignored", 64'(rsp_code), 4);
   endtask

   task automatic t_repl();
      for (int i = 0; i < 8; i++) begin
         do_fill(20'h00100 + 20'(i), desc(2'b01, 1, 1, 1, 1, 0, 1, 24'h000500 + 24'(i)));
      end
      do_fill(20'h00060, desc(2'b00, 1, 1, 1, 1, 0, 1, 24'h000666));
      do_req({20'h00100, 12'h0}, 0, 0, 0, 1);
      check(rsp_hit, "R13 kind 0 evicts nothing", 64'(rsp_code), 0);
      do_fill(20'h00108, desc(2'b01, 1, 1, 1, 1, 0, 1, 24'h000508));
      do_req({20'h00100, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R11 entry 0 evicted", 64'(rsp_code), 4);
      do_req({20'h00101, 12'h0}, 0, 0, 0, 1);
      check(rsp_hit, "R11 entry 1 kept", 64'(rsp_code), 0);
      do_req({20'h00108, 12'hABC}, 0, 0, 0, 1);
      check(rsp_paddr == {24'h000508, 12'hABC}, "R11 new entry", 64'(rsp_paddr), 64'h508ABC);
      do_fill(20'h00109, desc(2'b01, 1, 1, 1, 1, 0, 1, 24'h000509));
      do_req({20'h00101, 12'h0}, 0, 0, 0, 1);
      check(rsp_miss, "R11 pointer advanced", 64'(rsp_code), 4);
      do_req({20'h00102, 12'h0}, 0, 0, 0, 1);
      check(rsp_hit, "R11 entry 2 kept", 64'(rsp_code), 0);
   endtask

   task automatic t_disable();
      do_cfg(2'd1, 20'h0);
      do_req(32'h0005_5123, 1, 0, 1, 0);
      check(rsp_hit && !rsp_miss && rsp_paddr == 36'h0_0005_5123, "R12 off passthrough",
            64'(rsp_paddr), 64'h55123);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_passthrough();
      t_hit();
      t_miss();
      t_faults();
      t_dirty();
      t_ctx();
      t_inval();
      t_kind0();
      t_repl();
      t_disable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule